// File: doc/BRIEF.md
# Hybrid Nonvolatile Cache Bank Controller

This block sequences one bank of a four-way set-associative cache. The tags and their valid bits sit in fast volatile storage inside the block. The line data sits in an external array of resistive nonvolatile cells, and those cells are slow to program. Every access runs its tag lookup first, and it does so in a cycle of its own. Only after a hit does the block open one data column, and that column belongs to the hit way. The columns of the other ways in the row stay unbiased.

Each data cell has two access devices, and each device has its own word line. A read opens word line 1 alone for one access slot. A write raises both word lines together and holds them for two slots, which stretches the programming pulse. The array returns one comparator result per bit. The block turns these results into data bits, taking the high-resistance state as a logic one.

A write miss allocates a way in the tag store within a single cycle, and the data pulse follows. A read miss returns a miss response straight after the tag phase and never touches the data array.

Top module: `hnvc_bank_ctrl`

## Requirements
- R1: After reset every valid bit is clear, so every first read misses. `req_ready_o` is 1. `arr_wl1_o`, `arr_wl2_o`, `arr_col_o` and `rsp_valid_o` are all 0.
- R2: An accepted request spends exactly one cycle in a tag phase before any word line rises. The address splits, from the top down, into tag, set (4 bits), word-in-line (4 bits) and byte (2 bits, which must be zero). Lines are 64 bytes long.
- R3: During a data access exactly one column-select bit is 1. Bit w selects way w and is the hit or allocated way. The select stays constant for the whole access.
- R4: A read hit raises `arr_wl1_o` for exactly SLOT_CYC cycles (default 2), and `arr_wl2_o` stays 0 throughout.
- R5: A write raises `arr_wl1_o` and `arr_wl2_o` together for exactly 2*SLOT_CYC cycles and drops both together. `arr_hires_o` bit b equals write-data bit b during the pulse, where 1 means the high-resistance state.
- R6: Read data bit b is 1 when `arr_hicur_i` bit b is 0, meaning the cell current is below the reference. It is 0 when the current is above the reference.
- R7: A read miss asserts no column and no word line. It answers with `rsp_hit_o`=0 two cycles after acceptance.
- R8: `req_ready_o` is 0 from acceptance until the response cycle. A request held pending during a write pulse is accepted only when the pulse ends, and it then observes the written data.
- R9: A write miss allocates the lowest-numbered invalid way of the set. If all four ways are valid, it takes a bank-wide rotating pointer. The pointer starts at 0 and advances by one (mod 4) on each such eviction. A tag is never present twice in one set.
- R10: A write hit programs the way that already holds the tag. `rsp_hit_o` reports the lookup result from before any allocation.
- R11: Responses come 2+SLOT_CYC cycles after acceptance for a read hit, 2 cycles for a read miss, and 2+2*SLOT_CYC cycles for any write. In each case `rsp_valid_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte address, word aligned |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_rdata_o | output | 32 | Read data (valid on read hit) |
| arr_row_o | output | 8 | Data-array row: {set, word} |
| arr_wl1_o | output | 1 | Word line 1 of the selected row |
| arr_wl2_o | output | 1 | Word line 2 of the selected row |
| arr_col_o | output | 4 | Column select, one bit per way |
| arr_hires_o | output | 32 | Per-bit program target, 1 = high resistance |
| arr_hicur_i | input | 32 | Per-bit sense result, 1 = current above reference |

## Verification
Some properties are checked on every cycle: the word-line discipline (line 2 never alone, both lines falling together, exact pulse lengths for reads and writes), the one-hot column that stays stable through an access, a tag phase before every column opens, ready held low whenever a word line is up, and no duplicate tag within a set. Other behaviour shows only in the bench scenarios, which check it against a shadow tag model and a cell-array model. This covers the choice of victim way, the pointer rotation on evictions, hit reporting before allocation, the decoding of sense polarity on all-ones and all-zero words, response latency, and a request held across a write pulse that then reads back the fresh data.

// File: rtl/hnvc_pkg.sv
`timescale 1ns/1ps
package hnvc_pkg;

    // Controller phases of one bank access
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } ctrl_st_e;

endpackage

// File: rtl/hnvc_tag_store.sv
`timescale 1ns/1ps
module hnvc_tag_store #(
    parameter  int WAYS  = 4,
    parameter  int SETS  = 16,
    parameter  int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set_i,
    input  logic [TAG_W-1:0] lk_tag_i,
    output logic             lk_hit_o,
    output logic [WAY_W-1:0] lk_way_o,
    output logic [WAY_W-1:0] vic_way_o,
    input  logic             upd_en_i,
    input  logic [WAY_W-1:0] upd_way_i
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [WAY_W-1:0]                     rr;
    } tag_st_s;

    tag_st_s s_d, s_q;

    logic [WAYS-1:0]  match;
    logic [WAYS-1:0]  set_vld;
    logic             set_full;
    logic [WAY_W-1:0] free_way;

    assign set_vld  = s_q.vld[lk_set_i];
    assign set_full = &set_vld;

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = set_vld[w] && (s_q.tag[lk_set_i][w] == lk_tag_i);
        end
    endgenerate

    always_comb begin
        lk_way_o = '0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i])    lk_way_o = WAY_W'(i);
            if (!set_vld[i]) free_way = WAY_W'(i);
        end
    end

    assign lk_hit_o  = |match;
    assign vic_way_o = set_full ? s_q.rr : free_way;

    always_comb begin
        s_d = s_q;
        if (upd_en_i) begin
            s_d.tag[lk_set_i][upd_way_i] = lk_tag_i;
            s_d.vld[lk_set_i][upd_way_i] = 1'b1;
            if (set_full) begin
                if (s_q.rr == WAY_W'(WAYS - 1)) s_d.rr = '0;
                else                            s_d.rr = s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> s_q.vld[$past(lk_set_i)][$past(upd_way_i)]);

endmodule

// File: rtl/hnvc_pulse_timer.sv
`timescale 1ns/1ps
module hnvc_pulse_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = len_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == '0);

    // R5
    no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> last_o);

endmodule

// File: rtl/hnvc_sense_codec.sv
`timescale 1ns/1ps
module hnvc_sense_codec #(
    parameter int W = 32
) (
    input  logic [W-1:0] hicur_i,
    input  logic [W-1:0] wdata_i,
    input  logic         drive_i,
    output logic [W-1:0] rdata_o,
    output logic [W-1:0] hires_o
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            // low current means high resistance, which stores a one
            assign rdata_o[b] = ~hicur_i[b];
            assign hires_o[b] = drive_i & wdata_i[b];
        end
    endgenerate

endmodule

// File: rtl/hnvc_bank_ctrl.sv
`timescale 1ns/1ps
module hnvc_bank_ctrl
    import hnvc_pkg::*;
#(
    parameter  int ADDR_W     = 16,
    parameter  int DATA_W     = 32,
    parameter  int WAYS       = 4,
    parameter  int SETS       = 16,
    parameter  int LINE_BYTES = 64,
    parameter  int SLOT_CYC   = 2,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int BYTE_W     = $clog2(DATA_W / 8),
    localparam int WORD_W     = OFF_W - BYTE_W,
    localparam int SET_W      = $clog2(SETS),
    localparam int TAG_W      = ADDR_W - OFF_W - SET_W,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int ROW_W      = SET_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic [ROW_W-1:0]  arr_row_o,
    output logic              arr_wl1_o,
    output logic              arr_wl2_o,
    output logic [WAYS-1:0]   arr_col_o,
    output logic [DATA_W-1:0] arr_hires_o,
    input  logic [DATA_W-1:0] arr_hicur_i
);

    localparam int WR_CYC = 2 * SLOT_CYC;
    localparam int CNT_W  = $clog2(WR_CYC + 1);

    typedef struct packed {
        ctrl_st_e            st;
        logic                wr;
        logic [TAG_W-1:0]    tag;
        logic [SET_W-1:0]    set;
        logic [WORD_W-1:0]   word;
        logic [DATA_W-1:0]   wdata;
        logic [WAY_W-1:0]    way;
        logic                hit;
        logic                rsp_v;
        logic                rsp_hit;
        logic [DATA_W-1:0]   rdata;
    } ctrl_s;

    ctrl_s c_d, c_q;

    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;
    logic [WAY_W-1:0] vic_way;
    logic             upd_en;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;
    logic             wl_on;
    logic [DATA_W-1:0] dec_rdata;

    hnvc_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set_i  (c_q.set),
        .lk_tag_i  (c_q.tag),
        .lk_hit_o  (lk_hit),
        .lk_way_o  (lk_way),
        .vic_way_o (vic_way),
        .upd_en_i  (upd_en),
        .upd_way_i (c_d.way)
    );

    hnvc_pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .last_o (tmr_last)
    );

    hnvc_sense_codec #(
        .W (DATA_W)
    ) u_codec (
        .hicur_i (arr_hicur_i),
        .wdata_i (c_q.wdata),
        .drive_i (c_q.st == ST_WR),
        .rdata_o (dec_rdata),
        .hires_o (arr_hires_o)
    );

    always_comb begin
        c_d       = c_q;
        c_d.rsp_v = 1'b0;
        upd_en    = 1'b0;
        tmr_load  = 1'b0;
        tmr_len   = '0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    c_d.st    = ST_TAG;
                    c_d.wr    = req_write_i;
                    c_d.tag   = req_addr_i[ADDR_W-1 -: TAG_W];
                    c_d.set   = req_addr_i[OFF_W +: SET_W];
                    c_d.word  = req_addr_i[BYTE_W +: WORD_W];
                    c_d.wdata = req_wdata_i;
                end
            end
            ST_TAG: begin
                c_d.hit = lk_hit;
                c_d.way = lk_way;
                if (c_q.wr) begin
                    if (!lk_hit) begin
                        upd_en  = 1'b1;
                        c_d.way = vic_way;
                    end
                    c_d.st   = ST_WR;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(WR_CYC - 1);
                end else if (lk_hit) begin
                    c_d.st   = ST_RD;
                    tmr_load = 1'b1;
                    tmr_len  = CNT_W'(SLOT_CYC - 1);
                end else begin
                    c_d.st      = ST_IDLE;
                    c_d.rsp_v   = 1'b1;
                    c_d.rsp_hit = 1'b0;
                end
            end
            ST_RD: begin
                if (tmr_last) begin
                    c_d.st      = ST_IDLE;
                    c_d.rdata   = dec_rdata;
                    c_d.rsp_v   = 1'b1;
                    c_d.rsp_hit = 1'b1;
                end
            end
            ST_WR: begin
                if (tmr_last) begin
                    c_d.st      = ST_IDLE;
                    c_d.rsp_v   = 1'b1;
                    c_d.rsp_hit = c_q.hit;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign wl_on       = (c_q.st == ST_RD) || (c_q.st == ST_WR);
    assign req_ready_o = (c_q.st == ST_IDLE);
    assign rsp_valid_o = c_q.rsp_v;
    assign rsp_hit_o   = c_q.rsp_hit;
    assign rsp_rdata_o = c_q.rdata;
    assign arr_row_o   = {c_q.set, c_q.word};
    assign arr_wl1_o   = wl_on;
    assign arr_wl2_o   = (c_q.st == ST_WR);

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_col
            assign arr_col_o[w] = wl_on && (c_q.way == WAY_W'(w));
        end
    endgenerate

    // checker-side run lengths of the word-line pulses
    logic [CNT_W:0] run1_q, run2_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run1_q <= '0;
            run2_q <= '0;
        end else begin
            run1_q <= arr_wl1_o ? run1_q + 1'b1 : '0;
            run2_q <= arr_wl2_o ? run2_q + 1'b1 : '0;
        end
    end

    // R2
    aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |-> (req_addr_i[BYTE_W-1:0] == '0));

    // R2
    tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_wl1_o) |-> $past(c_q.st == ST_TAG));

    // R3
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arr_col_o));

    // R3
    col_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wl1_o && $past(arr_wl1_o)) |-> ($stable(arr_col_o) && $stable(arr_row_o)));

    // R4
    rd_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(arr_wl1_o) && !$past(arr_wl2_o)) |-> (run1_q == (CNT_W+1)'(SLOT_CYC)));

    // R5
    wl2_needs_wl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wl2_o |-> arr_wl1_o);

    // R5
    wr_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arr_wl2_o) |-> ((run2_q == (CNT_W+1)'(WR_CYC)) && !arr_wl1_o));

    // R7
    miss_no_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_TAG && !c_q.wr && !lk_hit) |=> (rsp_valid_o && !rsp_hit_o && !arr_wl1_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wl1_o |-> !req_ready_o);

endmodule

// File: tb/tb_hnvc_bank_ctrl.sv
`timescale 1ns/1ps
module tb_hnvc_bank_ctrl;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int WAYS   = 4;
    localparam int SETS   = 16;
    localparam int WORDS  = 16;
    localparam int SLOT   = 2;
    localparam int ROW_W  = 8;
    localparam int NCELL  = SETS * WORDS * WAYS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready_o;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid_o, rsp_hit_o;
    logic [DATA_W-1:0] rsp_rdata_o;
    logic [ROW_W-1:0]  arr_row_o;
    logic              arr_wl1_o, arr_wl2_o;
    logic [WAYS-1:0]   arr_col_o;
    logic [DATA_W-1:0] arr_hires_o;
    logic [DATA_W-1:0] arr_hicur;

    hnvc_bank_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready_o),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rsp_valid_o (rsp_valid_o),
        .rsp_hit_o   (rsp_hit_o),
        .rsp_rdata_o (rsp_rdata_o),
        .arr_row_o   (arr_row_o),
        .arr_wl1_o   (arr_wl1_o),
        .arr_wl2_o   (arr_wl2_o),
        .arr_col_o   (arr_col_o),
        .arr_hires_o (arr_hires_o),
        .arr_hicur_i (arr_hicur)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // ---------------- data-array cell model ----------------
    logic [DATA_W-1:0] cells [NCELL];
    int                pulse_run = 0;
    int                pulse_idx = 0;
    logic [DATA_W-1:0] pulse_bits = '0;
    int                bad_pulse = 0;

    function automatic int col_way(input logic [WAYS-1:0] c);
        int r = -1;
        for (int i = 0; i < WAYS; i++) if (c[i]) r = i;
        return r;
    endfunction

    always @* begin
        arr_hicur = '0;
        if (arr_wl1_o && col_way(arr_col_o) >= 0)
            arr_hicur = ~cells[int'(arr_row_o) * WAYS + col_way(arr_col_o)];
    end

    always @(posedge clk) begin
        if (arr_wl1_o && arr_wl2_o) begin
            pulse_run++;
            pulse_idx  = int'(arr_row_o) * WAYS + col_way(arr_col_o);
            pulse_bits = arr_hires_o;
        end else if (pulse_run != 0) begin
            if (pulse_run == 2 * SLOT) cells[pulse_idx] = pulse_bits;
            else bad_pulse++;
            pulse_run = 0;
        end
    end

    // ---------------- reference tag and data model ----------------
    int   rtag [SETS][WAYS];
    bit   rvld [SETS][WAYS];
    int   rr = 0;
    logic [DATA_W-1:0] rdat [SETS][WAYS][WORDS];
    bit   rknown [SETS][WAYS][WORDS];

    int   e_way;
    bit   e_hit;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // predicts hit/way and updates the reference tags for a write
    task automatic predict(input bit wr, input int tg, input int st);
        bit full = 1;
        int free = -1;
        e_hit = 0;
        e_way = -1;
        for (int w = 0; w < WAYS; w++) if (rvld[st][w] && rtag[st][w] == tg) begin e_hit = 1; e_way = w; end
        if (wr && !e_hit) begin
            for (int w = WAYS - 1; w >= 0; w--) if (!rvld[st][w]) begin free = w; full = 0; end
            if (full) begin e_way = rr; rr = (rr + 1) % WAYS; end
            else e_way = free;
            rvld[st][e_way] = 1;
            rtag[st][e_way] = tg;
            for (int k = 0; k < WORDS; k++) rknown[st][e_way][k] = 0;
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(input int tg, input int st, input int wd);
        return ADDR_W'((tg << 10) | (st << 6) | (wd << 2));
    endfunction

    // observes one access from the cycle after acceptance to its response
    task automatic collect(input bit wr, input int st, input int wd, input logic [DATA_W-1:0] wdat);
        int cyc = 1;
        bit got = 0;
        int wl1n = 0, wl2n = 0, rdyn = 0;
        logic [WAYS-1:0] cols = '0;
        int exp_lat;
        logic [WAYS-1:0] exp_cols;
        exp_cols = (e_way >= 0 && (wr || e_hit)) ? WAYS'(1 << e_way) : '0;
        exp_lat  = wr ? 2 + 2 * SLOT : (e_hit ? 2 + SLOT : 2);
        while (!got && cyc < 64) begin
            if (rsp_valid_o) got = 1;
            else begin
                wl1n += int'(arr_wl1_o);
                wl2n += int'(arr_wl2_o);
                rdyn += int'(req_ready_o);
                cols |= arr_col_o;
                @(negedge clk);
                cyc++;
            end
        end
        // R11 response latency
        chk(got && cyc == exp_lat, "R11 latency", cyc, exp_lat);
        // R9 / R10 hit flag reflects lookup before allocation
        chk(rsp_hit_o == e_hit, wr ? "R10 write hit flag" : "R9 read hit flag", rsp_hit_o, e_hit);
        // R3 column of the selected way only
        chk(cols == exp_cols, "R3 column select", cols, exp_cols);
        // R8 ready low while busy
        chk(rdyn == 0, "R8 ready during access", rdyn, 0);
        if (wr) begin
            // R5 stretched dual word-line pulse
            chk(wl1n == 2 * SLOT && wl2n == 2 * SLOT, "R5 write pulse", {wl1n, wl2n}, {2 * SLOT, 2 * SLOT});
            rdat[st][e_way][wd]   = wdat;
            rknown[st][e_way][wd] = 1;
        end else if (e_hit) begin
            // R4 read opens word line 1 only
            chk(wl1n == SLOT && wl2n == 0, "R4 read word lines", {wl1n, wl2n}, {SLOT, 0});
            // R6 sense decode
            if (rknown[st][e_way][wd])
                chk(rsp_rdata_o == rdat[st][e_way][wd], "R6 read data", rsp_rdata_o, rdat[st][e_way][wd]);
        end else begin
            // R7 miss touches no word line
            chk(wl1n == 0 && wl2n == 0, "R7 miss word lines", {wl1n, wl2n}, 0);
        end
    endtask

    task automatic txn(input bit wr, input int tg, input int st, input int wd, input logic [DATA_W-1:0] wdat);
        predict(wr, tg, st);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = mk_addr(tg, st, wd);
        req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        collect(wr, st, wd, wdat);
    endtask

    function automatic logic [DATA_W-1:0] pat(input int k, input int s);
        if (k == 0) return '1;
        if (k == 1) return '0;
        return DATA_W'(32'h5A3C0000 ^ ((k * 131 + s * 7919) * 32'h9E3779B1));
    endfunction

    initial begin
        for (int i = 0; i < NCELL; i++) cells[i] = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                rvld[s][w] = 0;
                rtag[s][w] = 0;
                for (int k = 0; k < WORDS; k++) begin rknown[s][w][k] = 0; rdat[s][w][k] = '0; end
            end
    end

    initial begin : main
        int waitn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(req_ready_o == 1'b1, "R1 ready after reset", req_ready_o, 1);
        chk(!arr_wl1_o && !arr_wl2_o && arr_col_o == '0, "R1 lines idle", {arr_wl1_o, arr_wl2_o, arr_col_o}, 0);
        chk(rsp_valid_o == 1'b0, "R1 no response", rsp_valid_o, 0);

        // R1 / R7: every set misses from reset
        for (int s = 0; s < SETS; s++) txn(0, 3, s, s, '0);

        // R9 allocation sweep: six tags per set, filling and evicting
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < 6; k++) txn(1, (k * 5 + s) % 64, s, (k + s) % WORDS, pat(k, s));
            for (int k = 0; k < 6; k++) txn(0, (k * 5 + s) % 64, s, (k + s) % WORDS, '0);
        end

        // R10 write hits to resident lines, then read back
        for (int s = 0; s < SETS; s++) begin
            txn(1, (5 * 5 + s) % 64, s, (s + 9) % WORDS, ~pat(s + 2, s));
            txn(0, (5 * 5 + s) % 64, s, (s + 9) % WORDS, '0);
        end

        // R8 request held pending across a write pulse
        predict(1, 40, 2);
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = mk_addr(40, 2, 7);
        req_wdata = 32'hC0DE_F00D;
        @(negedge clk);
        req_write = 1'b0;
        waitn = 0;
        while (!req_ready_o && waitn < 64) begin waitn++; @(negedge clk); end
        chk(waitn == 1 + 2 * SLOT, "R8 hold length", waitn, 1 + 2 * SLOT);
        chk(rsp_valid_o == 1'b1, "R8 write response at release", rsp_valid_o, 1);
        rdat[2][e_way][7]   = 32'hC0DE_F00D;
        rknown[2][e_way][7] = 1;
        predict(0, 40, 2);
        @(negedge clk);
        req_valid = 1'b0;
        collect(0, 2, 7, '0);
        chk(rsp_rdata_o == 32'hC0DE_F00D, "R8 pending read sees write", rsp_rdata_o, 32'hC0DE_F00D);

        // R5 cell model saw only full-length pulses
        chk(bad_pulse == 0, "R5 pulse length at array", bad_pulse, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule